// File: doc/BRIEF.md
# Register-Port-Limited Micro-Operation Splitter

This block sits between instruction decode and issue in a core whose register file offers two read ports and one write port. It accepts one decoded instruction at a time and emits the micro-operations needed to carry it out. No micro-operation reads more than two registers or writes more than one. Each emitted micro-operation carries its own kind code, two source indices with enables, one destination index with an enable, and a flag that marks the final micro-operation of the instruction.

Instructions that fit the port budget pass through as one micro-operation. A paired-register move, a multiply-accumulate, a register-offset store and a divide that yields both quotient and remainder are each split into two steps in a fixed order. Multi-word loads and stores are split into one step per listed register, taken in ascending register order. When the base register is updated, one extra write-back step follows at the end. Both sides of the block use a valid/ready handshake.

Top module: `ucr_top`

## Requirements
- R1: `in_ready` is 1 exactly when no instruction is in flight. It falls after an instruction is accepted and rises again in the cycle after its last micro-operation is accepted. While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R2: Every micro-operation drives 0 on any index whose enable is 0. Instruction kind 0 (plain) produces one micro-operation of kind 0 that reads `ra`, `rb`, writes `rd` and has `out_last`=1.
- R3: Kind 1 (paired move) produces kind 1 twice. The first reads `ra` with bit 0 cleared and writes `rd` with bit 0 cleared. The second reads `ra` with bit 0 set and writes `rd` with bit 0 set, and is last.
- R4: Kind 2 (multiply-accumulate) produces kind 2, which reads `ra` and `rb` and writes nothing. It is followed by kind 3, which reads `rd` and writes `rd`, and is last.
- R5: Kind 3 (register-offset store) produces kind 4, which reads `ra` and `rb`, then kind 5, which reads the data register `rc` and is last. Kind 4 (immediate-offset store) produces a single kind 6 that reads `ra` and `rc`. Neither store step writes a register.
- R6: Kind 5 (multi-word load) produces one kind 7 per set bit of `in_list`, in ascending index order. Each one reads `ra` and writes that index.
- R7: Kind 6 (multi-word store) produces one kind 8 per set bit of `in_list`, in ascending index order. Each one reads `ra` on port 1 and that index on port 2, and writes nothing.
- R8: For kinds 5 and 6 with `in_wb`=1, a final kind 9 follows the list. It reads `ra`, writes `ra` and is last. With `in_wb`=0, the last list step carries `out_last`.
- R9: Kind 7 (divide with remainder) produces kind 10, which reads `ra` and `rb` and writes `rd`. It is followed by kind 11, which reads `ra` and `rb`, writes `rc` and is last.
- R10: Kind 5 or 6 with an empty `in_list` and `in_wb`=0 produces a single kind 12 with no enables set and `out_last`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Splitter idle, can take an instruction |
| in_kind | input | 3 | Instruction kind code (R2 to R10) |
| in_rd | input | RW | Destination / accumulator register |
| in_ra | input | RW | First source or base register |
| in_rb | input | RW | Second source or offset register |
| in_rc | input | RW | Store data or remainder register |
| in_list | input | NREGS | Register list for multi-word accesses |
| in_wb | input | 1 | Multi-word access updates its base |
| out_valid | output | 1 | Micro-operation offered |
| out_ready | input | 1 | Issue takes the micro-operation |
| out_op | output | 4 | Micro-operation kind code |
| out_rs1 | output | RW | Read port 1 index |
| out_rs1_en | output | 1 | Read port 1 used |
| out_rs2 | output | RW | Read port 2 index |
| out_rs2_en | output | 1 | Read port 2 used |
| out_rd | output | RW | Write port index |
| out_rd_en | output | 1 | Write port used |
| out_last | output | 1 | Final micro-operation of the instruction |

## Verification
The bench targets lists with a single entry, with all entries set and with none set, with and without base write-back, and paired moves given odd register numbers. A design that mishandled these would drop or repeat a list step, leave the write-back out or put it in the wrong place, or write the odd half of a pair first. It also holds `out_ready` low at random. A sequencer that advanced without a handshake would skip micro-operations, and one that reopened its input early would let a second instruction overlap the first.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

   typedef enum logic [2:0] {
      IK_PLAIN  = 3'd0,
      IK_DMOV   = 3'd1,
      IK_MAC    = 3'd2,
      IK_ST_RR  = 3'd3,
      IK_ST_RI  = 3'd4,
      IK_LDM    = 3'd5,
      IK_STM    = 3'd6,
      IK_DIVREM = 3'd7
   } ikind_e;

   typedef enum logic [3:0] {
      UO_PASS = 4'd0,
      UO_MOVE = 4'd1,
      UO_MUL  = 4'd2,
      UO_ACC  = 4'd3,
      UO_AGEN = 4'd4,
      UO_SDAT = 4'd5,
      UO_STI  = 4'd6,
      UO_LDW  = 4'd7,
      UO_STW  = 4'd8,
      UO_BASE = 4'd9,
      UO_QUOT = 4'd10,
      UO_REM  = 4'd11,
      UO_NOP  = 4'd12
   } uop_e;

   function automatic logic is_list_kind(ikind_e k);
      return (k == IK_LDM) || (k == IK_STM);
   endfunction

   function automatic logic is_pair_kind(ikind_e k);
      return (k == IK_DMOV) || (k == IK_MAC) || (k == IK_ST_RR) || (k == IK_DIVREM);
   endfunction

endpackage

// File: rtl/ucr_lowbit.sv
module ucr_lowbit #(
   parameter int NREGS = 32,
   localparam int RW = $clog2(NREGS)
) (
   input  logic [NREGS-1:0] mask,
   output logic             any,
   output logic [RW-1:0]    idx,
   output logic [NREGS-1:0] rest,
   output logic             rest_any
);

   logic [NREGS-1:0] below;
   logic [NREGS-1:0] pick;

   genvar gi;
   generate
      for (gi = 0; gi < NREGS; gi++) begin : g_below
         if (gi == 0) begin : g_first
            assign below[gi] = 1'b0;
         end else begin : g_rest
            assign below[gi] = |mask[gi-1:0];
         end
      end
   endgenerate

   assign pick     = mask & ~below;
   assign rest     = mask & ~pick;
   assign any      = |mask;
   assign rest_any = |rest;

   always_comb begin
      idx = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (pick[i]) idx = idx | RW'(i);
      end
   end

endmodule

// File: rtl/ucr_form.sv
module ucr_form
   import ucr_pkg::*;
#(
   parameter int NREGS = 32,
   localparam int RW = $clog2(NREGS)
) (
   input  ikind_e         kind,
   input  logic [RW-1:0]  rd,
   input  logic [RW-1:0]  ra,
   input  logic [RW-1:0]  rb,
   input  logic [RW-1:0]  rc,
   input  logic           wb,
   input  logic           step,
   input  logic           lst_any,
   input  logic [RW-1:0]  lst_idx,
   input  logic           lst_rest_any,
   output uop_e           op,
   output logic [RW-1:0]  rs1,
   output logic           rs1_en,
   output logic [RW-1:0]  rs2,
   output logic           rs2_en,
   output logic [RW-1:0]  wr,
   output logic           wr_en,
   output logic           last
);

   localparam logic [RW-1:0] ODD = RW'(1);

   always_comb begin
      op     = UO_NOP;
      rs1    = '0;
      rs1_en = 1'b0;
      rs2    = '0;
      rs2_en = 1'b0;
      wr     = '0;
      wr_en  = 1'b0;
      last   = 1'b1;
      unique case (kind)
         IK_PLAIN: begin
            op = UO_PASS;
            rs1 = ra; rs1_en = 1'b1;
            rs2 = rb; rs2_en = 1'b1;
            wr  = rd; wr_en  = 1'b1;
         end
         IK_DMOV: begin
            op = UO_MOVE;
            last = step;
            rs1 = step ? (ra | ODD) : (ra & ~ODD); rs1_en = 1'b1;
            wr  = step ? (rd | ODD) : (rd & ~ODD); wr_en  = 1'b1;
         end
         IK_MAC: begin
            last = step;
            if (!step) begin
               op = UO_MUL;
               rs1 = ra; rs1_en = 1'b1;
               rs2 = rb; rs2_en = 1'b1;
            end else begin
               op = UO_ACC;
               rs1 = rd; rs1_en = 1'b1;
               wr  = rd; wr_en  = 1'b1;
            end
         end
         IK_ST_RR: begin
            last = step;
            if (!step) begin
               op = UO_AGEN;
               rs1 = ra; rs1_en = 1'b1;
               rs2 = rb; rs2_en = 1'b1;
            end else begin
               op = UO_SDAT;
               rs1 = rc; rs1_en = 1'b1;
            end
         end
         IK_ST_RI: begin
            op = UO_STI;
            rs1 = ra; rs1_en = 1'b1;
            rs2 = rc; rs2_en = 1'b1;
         end
         IK_LDM, IK_STM: begin
            if (lst_any) begin
               last = !lst_rest_any && !wb;
               rs1 = ra; rs1_en = 1'b1;
               if (kind == IK_LDM) begin
                  op = UO_LDW;
                  wr = lst_idx; wr_en = 1'b1;
               end else begin
                  op = UO_STW;
                  rs2 = lst_idx; rs2_en = 1'b1;
               end
            end else if (wb) begin
               op = UO_BASE;
               rs1 = ra; rs1_en = 1'b1;
               wr  = ra; wr_en  = 1'b1;
            end
         end
         IK_DIVREM: begin
            last = step;
            op = step ? UO_REM : UO_QUOT;
            rs1 = ra; rs1_en = 1'b1;
            rs2 = rb; rs2_en = 1'b1;
            wr  = step ? rc : rd; wr_en = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ucr_top.sv
module ucr_top
   import ucr_pkg::*;
#(
   parameter int NREGS = 32,
   localparam int RW = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [2:0]       in_kind,
   input  logic [RW-1:0]    in_rd,
   input  logic [RW-1:0]    in_ra,
   input  logic [RW-1:0]    in_rb,
   input  logic [RW-1:0]    in_rc,
   input  logic [NREGS-1:0] in_list,
   input  logic             in_wb,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [3:0]       out_op,
   output logic [RW-1:0]    out_rs1,
   output logic             out_rs1_en,
   output logic [RW-1:0]    out_rs2,
   output logic             out_rs2_en,
   output logic [RW-1:0]    out_rd,
   output logic             out_rd_en,
   output logic             out_last
);

   initial begin
      if (NREGS < 4 || (1 << RW) != NREGS)
         $error("ucr_top: NREGS must be a power of two of at least 4");
   end

   logic             busy;
   logic             step;
   ikind_e           kind_q;
   logic [RW-1:0]    rd_q, ra_q, rb_q, rc_q;
   logic             wb_q;
   logic [NREGS-1:0] mask_q;

   logic             lst_any, lst_rest_any;
   logic [RW-1:0]    lst_idx;
   logic [NREGS-1:0] lst_rest;
   uop_e             op_w;
   logic             fire_in, fire_out;

   ucr_lowbit #(.NREGS(NREGS)) u_lowbit (
      .mask     (mask_q),
      .any      (lst_any),
      .idx      (lst_idx),
      .rest     (lst_rest),
      .rest_any (lst_rest_any)
   );

   ucr_form #(.NREGS(NREGS)) u_form (
      .kind         (kind_q),
      .rd           (rd_q),
      .ra           (ra_q),
      .rb           (rb_q),
      .rc           (rc_q),
      .wb           (wb_q),
      .step         (step),
      .lst_any      (lst_any),
      .lst_idx      (lst_idx),
      .lst_rest_any (lst_rest_any),
      .op           (op_w),
      .rs1          (out_rs1),
      .rs1_en       (out_rs1_en),
      .rs2          (out_rs2),
      .rs2_en       (out_rs2_en),
      .wr           (out_rd),
      .wr_en        (out_rd_en),
      .last         (out_last)
   );

   assign out_op    = op_w;
   assign out_valid = busy;
   assign in_ready  = !busy;
   assign fire_in   = in_valid && in_ready;
   assign fire_out  = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         step   <= 1'b0;
         kind_q <= IK_PLAIN;
         rd_q   <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
         rc_q   <= '0;
         wb_q   <= 1'b0;
         mask_q <= '0;
      end else if (fire_in) begin
         busy   <= 1'b1;
         step   <= 1'b0;
         kind_q <= ikind_e'(in_kind);
         rd_q   <= in_rd;
         ra_q   <= in_ra;
         rb_q   <= in_rb;
         rc_q   <= in_rc;
         wb_q   <= in_wb;
         mask_q <= is_list_kind(ikind_e'(in_kind)) ? in_list : '0;
      end else if (fire_out) begin
         if (out_last) begin
            busy <= 1'b0;
         end else begin
            step <= 1'b1;
            if (lst_any) mask_q <= lst_rest;
         end
      end
   end

   AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready); // R1

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd)
         && $stable(out_rs1) && $stable(out_rs2) && $stable(out_last))); // R1

   AST_DMOV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == 4'd1) |-> (out_rd[0] == out_last)); // R3

   AST_MUL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == 4'd2) |-> (!out_rd_en && !out_last)); // R4

   AST_LDM_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_out && out_op == 4'd7 && !out_last) |=>
         ((out_op == 4'd9) || (out_op == 4'd7 && out_rd > $past(out_rd)))); // R6

   AST_BASE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == 4'd9) |-> (out_last && out_rd == out_rs1 && out_rd_en)); // R8

   AST_NOP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == 4'd12) |->
         (out_last && !out_rs1_en && !out_rs2_en && !out_rd_en)); // R10

endmodule

// File: tb/ucr_top_test.sv
`timescale 1ns/1ps
module ucr_top_test;

   localparam int NREGS = 32;
   localparam int RW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [2:0] in_kind = '0;
   logic [RW-1:0] in_rd = '0, in_ra = '0, in_rb = '0, in_rc = '0;
   logic [NREGS-1:0] in_list = '0;
   logic in_wb = 1'b0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [3:0] out_op;
   logic [RW-1:0] out_rs1, out_rs2, out_rd;
   logic out_rs1_en, out_rs2_en, out_rd_en, out_last;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [22:0] exp_q [0:63];
   int exp_n;

   always #4 clk = ~clk;

   ucr_top #(.NREGS(NREGS)) uut (.*);

   function automatic logic [22:0] pk(logic [3:0] op, logic [4:0] a, logic ae,
                                      logic [4:0] b, logic be, logic [4:0] w, logic we, logic l);
      return {op, ae ? a : 5'd0, ae, be ? b : 5'd0, be, we ? w : 5'd0, we, l};
   endfunction

   function automatic string rq(int k, logic [NREGS-1:0] lst, logic wb);
      case (k)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3, 4: return "R5";
         5: return (lst == 0 && !wb) ? "R10" : (wb ? "R6/R8" : "R6");
         6: return (lst == 0 && !wb) ? "R10" : (wb ? "R7/R8" : "R7");
         default: return "R9";
      endcase
   endfunction

   task automatic push(logic [22:0] v);
      exp_q[exp_n] = v;
      exp_n++;
   endtask

   task automatic model(int k, logic [4:0] rd, logic [4:0] ra, logic [4:0] rb,
                        logic [4:0] rc, logic [NREGS-1:0] lst, logic wb);
      int cnt;
      int seen;
      exp_n = 0;
      case (k)
         0: push(pk(4'd0, ra, 1, rb, 1, rd, 1, 1));
         1: begin
            push(pk(4'd1, {ra[4:1], 1'b0}, 1, 0, 0, {rd[4:1], 1'b0}, 1, 0));
            push(pk(4'd1, {ra[4:1], 1'b1}, 1, 0, 0, {rd[4:1], 1'b1}, 1, 1));
         end
         2: begin
            push(pk(4'd2, ra, 1, rb, 1, 0, 0, 0));
            push(pk(4'd3, rd, 1, 0, 0, rd, 1, 1));
         end
         3: begin
            push(pk(4'd4, ra, 1, rb, 1, 0, 0, 0));
            push(pk(4'd5, rc, 1, 0, 0, 0, 0, 1));
         end
         4: push(pk(4'd6, ra, 1, rc, 1, 0, 0, 1));
         5, 6: begin
            cnt = $countones(lst);
            seen = 0;
            for (int i = 0; i < NREGS; i++) begin
               if (lst[i]) begin
                  seen++;
                  if (k == 5) push(pk(4'd7, ra, 1, 0, 0, 5'(i), 1, (seen == cnt) && !wb));
                  else        push(pk(4'd8, ra, 1, 5'(i), 1, 0, 0, (seen == cnt) && !wb));
               end
            end
            if (wb) push(pk(4'd9, ra, 1, 0, 0, ra, 1, 1));
            else if (cnt == 0) push(pk(4'd12, 0, 0, 0, 0, 0, 0, 1));
         end
         default: begin
            push(pk(4'd10, ra, 1, rb, 1, rd, 1, 0));
            push(pk(4'd11, ra, 1, rb, 1, rc, 1, 1));
         end
      endcase
   endtask

   task automatic run(int k, logic [4:0] rd, logic [4:0] ra, logic [4:0] rb,
                      logic [4:0] rc, logic [NREGS-1:0] lst, logic wb, int rdy_pct);
      int got;
      bit done;
      bit hold_prev;
      logic [22:0] act, prev;
      string tag;
      tag = rq(k, lst, wb);
      model(k, rd, ra, rb, rc, lst, wb);
      @(negedge clk);
      in_kind = 3'(k); in_rd = rd; in_ra = ra; in_rb = rb; in_rc = rc;
      in_list = lst; in_wb = wb; in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      got = 0; done = 0; hold_prev = 0; prev = '0;
      while (!done) begin
         @(negedge clk);
         out_ready = ($urandom_range(99) < rdy_pct);
         #1;
         act = {out_op, out_rs1, out_rs1_en, out_rs2, out_rs2_en, out_rd, out_rd_en, out_last};
         if (hold_prev) begin
            checks++;
            if (!out_valid || act !== prev) begin
               errors++;
               $display("FAIL R1 hold: actual %h valid %b expected %h", act, out_valid, prev);
            end
         end
         if (out_valid) begin
            checks++;
            if (in_ready !== 1'b0) begin
               errors++;
               $display("FAIL R1 in_ready while busy: actual %b expected 0", in_ready);
            end
         end
         hold_prev = out_valid && !out_ready;
         prev = act;
         if (out_valid && out_ready) begin
            checks++;
            if (got >= exp_n) begin
               errors++;
               $display("FAIL %s extra uop: actual %h expected none", tag, act);
               done = 1;
            end else begin
               if (act !== exp_q[got]) begin
                  errors++;
                  $display("FAIL %s kind %0d uop %0d: actual %h expected %h",
                           tag, k, got, act, exp_q[got]);
               end
               got++;
               if (out_last) done = 1;
            end
         end
      end
      @(negedge clk);
      out_ready = 1'b0;
      checks++;
      if (got != exp_n || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL %s/R1 count: actual %0d ready %b expected %0d ready 1",
                  tag, got, in_ready, exp_n);
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: actual ready %b valid %b expected 1 0", in_ready, out_valid);
      end
      // directed corners
      run(0, 5'd3, 5'd4, 5'd5, 5'd6, '0, 0, 100);                     // R2
      run(1, 5'd7, 5'd9, 5'd0, 5'd0, '0, 0, 100);                     // R3 odd given
      run(2, 5'd10, 5'd11, 5'd12, 5'd0, '0, 0, 50);                   // R4
      run(3, 5'd0, 5'd1, 5'd2, 5'd3, '0, 0, 100);                     // R5
      run(4, 5'd0, 5'd8, 5'd0, 5'd9, '0, 0, 100);                     // R5
      run(5, 5'd0, 5'd2, 5'd0, 5'd0, 32'h0000_0001, 0, 100);          // R6 single
      run(5, 5'd0, 5'd2, 5'd0, 5'd0, 32'hFFFF_FFFF, 1, 70);           // R6 R8 full
      run(6, 5'd0, 5'd30, 5'd0, 5'd0, 32'h8000_0010, 1, 60);          // R7 R8
      run(6, 5'd0, 5'd30, 5'd0, 5'd0, 32'h0000_0000, 1, 100);         // R8 only base
      run(5, 5'd0, 5'd1, 5'd0, 5'd0, 32'h0000_0000, 0, 100);          // R10
      run(6, 5'd0, 5'd1, 5'd0, 5'd0, 32'h0000_0000, 0, 40);           // R10
      run(7, 5'd13, 5'd14, 5'd15, 5'd16, '0, 0, 100);                 // R9
      // constrained random
      for (int n = 0; n < 400; n++) begin
         logic [NREGS-1:0] l;
         l = $urandom() & $urandom();
         run($urandom_range(7), 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
             l, 1'($urandom), 30 + $urandom_range(70));
      end
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule